// File: doc/BRIEF.md
# Banked Shadow General Register File

This block is the general-purpose register storage of a processor core, built from several complete banks of registers. A context number held inside the block picks which bank the core's two combinational read ports and its single write port reach. The core names only a register within a bank. The bank always comes from the context number.

Every word of every bank is also mapped into a flat special-register address window. Software can read or write any bank's registers there as scratch storage, whatever the current context. With fast context switching enabled, exception entry moves the context number up by one, so a handler starts on a fresh bank and nothing has to be spilled to memory. Exception return moves it back down. With the feature disabled, the context stays at bank 0 and the other banks are reachable only through the window. A constant configuration output tells software that shadow banks exist and how many banks there are.

Top module: `shreg_bank_file`

## Requirements
- R1: After reset, the context number is 0, both flags are low, and every word of every bank reads as zero.
- R2: The core read ports return, without a clock edge, the selected register of the bank named by `ctx_id`. A core write updates that register of the same bank, and the new value is visible from the next cycle.
- R3: A window address A with 1024 <= A <= 1535 maps to bank (A-1024)/32 and register (A-1024)%32. While `spr_en` is high, `spr_rdata` returns that word and `spr_miss` stays low.
- R4: A window write (`spr_en` and `spr_we` high, address inside the window) updates the mapped word in any bank, whether or not that bank is the current context.
- R5: An address below 1024 or above 1535 never hits storage. With `spr_en` high, `spr_miss` is 1 and `spr_rdata` is 0, and a write there changes no word. With `spr_en` low, `spr_miss` is 0 and `spr_rdata` is 0.
- R6: When a core write and a window write land on the same word in one cycle, the word takes the window data. Writes from the two ports to different words both take effect.
- R7: A read from any port of a word that is written in the same cycle returns the value the word held before that write.
- R8: With fast switching enabled, `exc_enter` alone raises `ctx_id` by one and `exc_return` alone lowers it by one, both at the next edge. If both are high in the same cycle, `ctx_id` does not change.
- R9: `exc_enter` at context 15 leaves the context at 15 and sets `ctx_ovf` for the single following cycle. `exc_return` at context 0 leaves the context at 0 and sets `ctx_udf` for the single following cycle. The context never wraps.
- R10: With fast switching disabled, `ctx_id` stays 0 and both flags stay low for any use of `exc_enter` and `exc_return`. The window still reaches all banks.
- R11: `cfg_shadow_present` is 1 when there is more than one bank, and `cfg_bank_count` equals the number of banks (16 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| core_rd_a_sel | input | 5 | Register select, core read port A |
| core_rd_a_data | output | 32 | Core read port A data |
| core_rd_b_sel | input | 5 | Register select, core read port B |
| core_rd_b_data | output | 32 | Core read port B data |
| core_we | input | 1 | Core write enable |
| core_wr_sel | input | 5 | Core write register select |
| core_wdata | input | 32 | Core write data |
| spr_en | input | 1 | Special-register access valid |
| spr_we | input | 1 | Special-register access is a write |
| spr_addr | input | 16 | Special-register index |
| spr_wdata | input | 32 | Special-register write data |
| spr_rdata | output | 32 | Special-register read data (zero on a miss) |
| spr_miss | output | 1 | Access falls outside the window |
| exc_enter | input | 1 | Exception entry: step the context up |
| exc_return | input | 1 | Exception return: step the context down |
| ctx_id | output | 4 | Current context (bank) number |
| ctx_ovf | output | 1 | Step up was refused at the top context |
| ctx_udf | output | 1 | Step down was refused at context 0 |
| cfg_shadow_present | output | 1 | Shadow banks exist |
| cfg_bank_count | output | 5 | Number of banks |

## Verification
The bench builds two copies side by side on the same stimulus. Both use the default 16 banks of 32 words. One has fast switching enabled and the other has it disabled. The enabled copy lets exception steps reach both saturation ends and shows that core ports follow the context into banks filled only through the window. The disabled copy shows the context pinned at 0 while the window still writes and reads all 512 words. Both copies are checked against a behavioural model on every clock, through directed collision, same-cycle and out-of-window cases, and then a long random run.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

  // Context step request decoded from the exception strobes.
  typedef enum logic [1:0] {
    CTX_HOLD = 2'd0,
    CTX_UP   = 2'd1,
    CTX_DOWN = 2'd2
  } ctx_op_e;

  localparam int unsigned SHREG_BANKS_DEF = 16;
  localparam int unsigned SHREG_REGS_DEF  = 32;
  localparam int unsigned SHREG_DATA_DEF  = 32;
  localparam int unsigned SHREG_SPRAW_DEF = 16;
  localparam int unsigned SHREG_BASE_DEF  = 1024;

endpackage

// File: rtl/shreg_win_decode.sv
module shreg_win_decode #(
  parameter int unsigned SPR_AW    = 16,
  parameter int unsigned WIN_BASE  = 1024,
  parameter int unsigned NUM_WORDS = 512,
  parameter int unsigned IDX_W     = 9
) (
  input  logic [SPR_AW-1:0] spr_addr,
  output logic              win_hit,
  output logic [IDX_W-1:0]  win_idx
);

  localparam logic [SPR_AW:0]   LO_V   = (SPR_AW+1)'(WIN_BASE);
  localparam logic [SPR_AW:0]   HI_V   = (SPR_AW+1)'(WIN_BASE + NUM_WORDS);
  localparam logic [SPR_AW-1:0] BASE_V = SPR_AW'(WIN_BASE);

  logic [SPR_AW:0]   addr_ext;
  logic [SPR_AW-1:0] addr_off;

  assign addr_ext = {1'b0, spr_addr};
  assign addr_off = spr_addr - BASE_V;
  assign win_hit  = (addr_ext >= LO_V) && (addr_ext < HI_V);
  // Banks and registers are powers of two, so {bank, reg} is the low offset bits.
  assign win_idx  = addr_off[IDX_W-1:0];

  logic unused_off_hi;
  assign unused_off_hi = ^addr_off[SPR_AW-1:IDX_W];

endmodule

// File: rtl/shreg_ctx.sv
module shreg_ctx
  import shreg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 16,
  parameter int unsigned CTX_W     = 4,
  parameter bit          FAST_CTX  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_up,
  input  logic             step_down,
  output logic [CTX_W-1:0] ctx_id,
  output logic             sat_hi,
  output logic             sat_lo
);

  localparam logic [CTX_W-1:0] TOP_CTX = CTX_W'(NUM_BANKS - 1);

  if (FAST_CTX) begin : g_fast
    ctx_op_e          op;
    logic [CTX_W-1:0] ctx_q, ctx_d;
    logic             hi_q, hi_d, lo_q, lo_d;

    always_comb begin
      op = CTX_HOLD;
      if (step_up && !step_down)      op = CTX_UP;
      else if (step_down && !step_up) op = CTX_DOWN;

      ctx_d = ctx_q;
      hi_d  = 1'b0;
      lo_d  = 1'b0;
      unique case (op)
        CTX_UP: begin
          if (ctx_q == TOP_CTX) hi_d = 1'b1;
          else                  ctx_d = ctx_q + 1'b1;
        end
        CTX_DOWN: begin
          if (ctx_q == '0) lo_d = 1'b1;
          else             ctx_d = ctx_q - 1'b1;
        end
        default: ;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctx_q <= '0;
        hi_q  <= 1'b0;
        lo_q  <= 1'b0;
      end else begin
        if (op != CTX_HOLD) ctx_q <= ctx_d;
        hi_q <= hi_d;
        lo_q <= lo_d;
      end
    end

    assign ctx_id = ctx_q;
    assign sat_hi = hi_q;
    assign sat_lo = lo_q;

    // R8
    ctx_up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_up && !step_down && ctx_id != TOP_CTX) |=> (ctx_id == $past(ctx_id) + 1'b1));

    // R8
    ctx_both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_up == step_down) |=> ($stable(ctx_id) && !sat_hi && !sat_lo));

    // R9
    ctx_sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_up && !step_down && ctx_id == TOP_CTX) |=> (sat_hi && ctx_id == TOP_CTX));

    // R9
    ctx_sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_down && !step_up && ctx_id == '0) |=> (sat_lo && ctx_id == '0));

    // R9
    ctx_flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sat_hi && sat_lo));
  end else begin : g_fixed
    assign ctx_id = '0;
    assign sat_hi = 1'b0;
    assign sat_lo = 1'b0;

    logic unused_steps;
    assign unused_steps = step_up ^ step_down ^ clk ^ rst_n;
  end

endmodule

// File: rtl/shreg_storage.sv
module shreg_storage #(
  parameter int unsigned NUM_WORDS = 512,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IDX_W     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_we,
  input  logic [IDX_W-1:0]  core_idx,
  input  logic [DATA_W-1:0] core_wdata,
  input  logic              win_we,
  input  logic [IDX_W-1:0]  win_idx,
  input  logic [DATA_W-1:0] win_wdata,
  input  logic [IDX_W-1:0]  rd_a_idx,
  input  logic [IDX_W-1:0]  rd_b_idx,
  input  logic [IDX_W-1:0]  rd_w_idx,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data,
  output logic [DATA_W-1:0] rd_w_data
);

  logic [DATA_W-1:0] mem_q [NUM_WORDS];
  logic [DATA_W-1:0] mem_d [NUM_WORDS];
  logic              core_drop;
  logic              core_eff;
  logic              wr_any;

  // The window port owns a word that both ports target in one cycle.
  assign core_drop = win_we && (win_idx == core_idx);
  assign core_eff  = core_we && !core_drop;
  assign wr_any    = core_eff || win_we;

  always_comb begin
    mem_d = mem_q;
    if (core_eff) mem_d[core_idx] = core_wdata;
    if (win_we)   mem_d[win_idx]  = win_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < int'(NUM_WORDS); w++) mem_q[w] <= '0;
    end else if (wr_any) begin
      mem_q <= mem_d;
    end
  end

  // Reads come from the registers, so a same-cycle write is not seen yet.
  assign rd_a_data = mem_q[rd_a_idx];
  assign rd_b_data = mem_q[rd_b_idx];
  assign rd_w_data = mem_q[rd_w_idx];

  // R4
  win_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_we |=> (mem_q[$past(win_idx)] == $past(win_wdata)));

  // R2
  core_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_we && !(win_we && win_idx == core_idx)) |=> (mem_q[$past(core_idx)] == $past(core_wdata)));

  // R6
  collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_we && win_we && win_idx == core_idx) |=> (rd_w_data == $past(win_wdata) || rd_w_idx != $past(win_idx)));

endmodule

// File: rtl/shreg_bank_file.sv
module shreg_bank_file
  import shreg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = SHREG_BANKS_DEF,
  parameter int unsigned NUM_REGS  = SHREG_REGS_DEF,
  parameter int unsigned DATA_W    = SHREG_DATA_DEF,
  parameter int unsigned SPR_AW    = SHREG_SPRAW_DEF,
  parameter int unsigned WIN_BASE  = SHREG_BASE_DEF,
  parameter bit          FAST_CTX  = 1'b1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [$clog2(NUM_REGS)-1:0]      core_rd_a_sel,
  output logic [DATA_W-1:0]                core_rd_a_data,
  input  logic [$clog2(NUM_REGS)-1:0]      core_rd_b_sel,
  output logic [DATA_W-1:0]                core_rd_b_data,
  input  logic                             core_we,
  input  logic [$clog2(NUM_REGS)-1:0]      core_wr_sel,
  input  logic [DATA_W-1:0]                core_wdata,
  input  logic                             spr_en,
  input  logic                             spr_we,
  input  logic [SPR_AW-1:0]                spr_addr,
  input  logic [DATA_W-1:0]                spr_wdata,
  output logic [DATA_W-1:0]                spr_rdata,
  output logic                             spr_miss,
  input  logic                             exc_enter,
  input  logic                             exc_return,
  output logic [$clog2(NUM_BANKS)-1:0]     ctx_id,
  output logic                             ctx_ovf,
  output logic                             ctx_udf,
  output logic                             cfg_shadow_present,
  output logic [$clog2(NUM_BANKS+1)-1:0]   cfg_bank_count
);

  localparam int unsigned NUM_WORDS = NUM_BANKS * NUM_REGS;
  localparam int unsigned BANK_AW   = $clog2(NUM_BANKS);
  localparam int unsigned REG_AW    = $clog2(NUM_REGS);
  localparam int unsigned IDX_W     = BANK_AW + REG_AW;
  localparam int unsigned CNT_W     = $clog2(NUM_BANKS + 1);

  // Reset: asserted asynchronously, released on the second clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Context number
  logic [BANK_AW-1:0] ctx_cur;

  shreg_ctx #(
    .NUM_BANKS (NUM_BANKS),
    .CTX_W     (BANK_AW),
    .FAST_CTX  (FAST_CTX)
  ) u_ctx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .step_up   (exc_enter),
    .step_down (exc_return),
    .ctx_id    (ctx_cur),
    .sat_hi    (ctx_ovf),
    .sat_lo    (ctx_udf)
  );

  assign ctx_id = ctx_cur;

  // Window decode
  logic             win_hit;
  logic [IDX_W-1:0] win_idx;
  logic             win_we;

  shreg_win_decode #(
    .SPR_AW    (SPR_AW),
    .WIN_BASE  (WIN_BASE),
    .NUM_WORDS (NUM_WORDS),
    .IDX_W     (IDX_W)
  ) u_dec (
    .spr_addr  (spr_addr),
    .win_hit   (win_hit),
    .win_idx   (win_idx)
  );

  assign win_we = spr_en && spr_we && win_hit;

  // Storage
  logic [IDX_W-1:0]  core_wr_idx, core_a_idx, core_b_idx;
  logic [DATA_W-1:0] win_rd_word;

  assign core_wr_idx = {ctx_cur, core_wr_sel};
  assign core_a_idx  = {ctx_cur, core_rd_a_sel};
  assign core_b_idx  = {ctx_cur, core_rd_b_sel};

  shreg_storage #(
    .NUM_WORDS  (NUM_WORDS),
    .DATA_W     (DATA_W),
    .IDX_W      (IDX_W)
  ) u_mem (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .core_we    (core_we),
    .core_idx   (core_wr_idx),
    .core_wdata (core_wdata),
    .win_we     (win_we),
    .win_idx    (win_idx),
    .win_wdata  (spr_wdata),
    .rd_a_idx   (core_a_idx),
    .rd_b_idx   (core_b_idx),
    .rd_w_idx   (win_idx),
    .rd_a_data  (core_rd_a_data),
    .rd_b_data  (core_rd_b_data),
    .rd_w_data  (win_rd_word)
  );

  assign spr_rdata = (spr_en && win_hit) ? win_rd_word : '0;
  assign spr_miss  = spr_en && !win_hit;

  // Configuration constants
  assign cfg_shadow_present = (NUM_BANKS > 1);
  assign cfg_bank_count     = CNT_W'(NUM_BANKS);

  // R5
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    spr_miss |-> (spr_rdata == '0));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !spr_en |-> (!spr_miss && spr_rdata == '0));

endmodule

// File: tb/test_shreg_bank_file.sv
module test_shreg_bank_file;

  localparam int NB   = 16;
  localparam int NR   = 32;
  localparam int BASE = 1024;
  localparam int NW   = NB * NR;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  rd_a_sel, rd_b_sel, wr_sel;
  logic        core_we, spr_en, spr_we, exc_enter, exc_return;
  logic [31:0] core_wdata, spr_wdata;
  logic [15:0] spr_addr;

  logic [31:0] f_a, f_b, f_s, x_a, x_b, x_s;
  logic        f_miss, x_miss, f_ovf, f_udf, x_ovf, x_udf, f_pres, x_pres;
  logic [3:0]  f_ctx, x_ctx;
  logic [4:0]  f_cnt, x_cnt;

  always #10 clk = ~clk;

  shreg_bank_file #(.FAST_CTX(1'b1)) i_shreg_bank_file (
    .clk(clk), .rst_n(rst_n),
    .core_rd_a_sel(rd_a_sel), .core_rd_a_data(f_a),
    .core_rd_b_sel(rd_b_sel), .core_rd_b_data(f_b),
    .core_we(core_we), .core_wr_sel(wr_sel), .core_wdata(core_wdata),
    .spr_en(spr_en), .spr_we(spr_we), .spr_addr(spr_addr), .spr_wdata(spr_wdata),
    .spr_rdata(f_s), .spr_miss(f_miss),
    .exc_enter(exc_enter), .exc_return(exc_return),
    .ctx_id(f_ctx), .ctx_ovf(f_ovf), .ctx_udf(f_udf),
    .cfg_shadow_present(f_pres), .cfg_bank_count(f_cnt)
  );

  shreg_bank_file #(.FAST_CTX(1'b0)) i_shreg_bank_file_fixed (
    .clk(clk), .rst_n(rst_n),
    .core_rd_a_sel(rd_a_sel), .core_rd_a_data(x_a),
    .core_rd_b_sel(rd_b_sel), .core_rd_b_data(x_b),
    .core_we(core_we), .core_wr_sel(wr_sel), .core_wdata(core_wdata),
    .spr_en(spr_en), .spr_we(spr_we), .spr_addr(spr_addr), .spr_wdata(spr_wdata),
    .spr_rdata(x_s), .spr_miss(x_miss),
    .exc_enter(exc_enter), .exc_return(exc_return),
    .ctx_id(x_ctx), .ctx_ovf(x_ovf), .ctx_udf(x_udf),
    .cfg_shadow_present(x_pres), .cfg_bank_count(x_cnt)
  );

  // Behavioural reference
  logic [31:0] mf [NB][NR];
  logic [31:0] mx [NB][NR];
  int          ctxf;
  bit          ovff, udff;

  int    tests = 0;
  int    fails = 0;
  bit    done  = 1'b0;
  string phase = "R1 reset";

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  task automatic compare();
    bit inw;
    int off, b, r;
    logic [31:0] ef, ex;
    inw = (int'(spr_addr) >= BASE) && (int'(spr_addr) < BASE + NW);
    off = int'(spr_addr) - BASE;
    b   = inw ? off / NR : 0;
    r   = inw ? off % NR : 0;
    ef  = (spr_en && inw) ? mf[b][r] : 32'h0;
    ex  = (spr_en && inw) ? mx[b][r] : 32'h0;
    chk("rd_a R2",            f_a, mf[ctxf][rd_a_sel]);
    chk("rd_b R2",            f_b, mf[ctxf][rd_b_sel]);
    chk("spr_rdata R3 R5",    f_s, ef);
    chk("spr_miss R5",        {31'd0, f_miss}, {31'd0, spr_en && !inw});
    chk("ctx_id R8",          {28'd0, f_ctx}, ctxf);
    chk("ovf R9",             {31'd0, f_ovf}, {31'd0, ovff});
    chk("udf R9",             {31'd0, f_udf}, {31'd0, udff});
    chk("cfg R11",            {26'd0, f_pres, f_cnt}, {26'd0, 1'b1, 5'd16});
    chk("fixed rd_a R10",     x_a, mx[0][rd_a_sel]);
    chk("fixed rd_b R10",     x_b, mx[0][rd_b_sel]);
    chk("fixed spr_rdata R10", x_s, ex);
    chk("fixed spr_miss R10", {31'd0, x_miss}, {31'd0, spr_en && !inw});
    chk("fixed ctx R10",      {28'd0, x_ctx}, 32'd0);
    chk("fixed flags R10",    {30'd0, x_ovf, x_udf}, 32'd0);
    chk("fixed cfg R11",      {26'd0, x_pres, x_cnt}, {26'd0, 1'b1, 5'd16});
  endtask

  task automatic update();
    bit inw;
    int off;
    inw = (int'(spr_addr) >= BASE) && (int'(spr_addr) < BASE + NW);
    off = int'(spr_addr) - BASE;
    if (core_we) begin
      mf[ctxf][wr_sel] = core_wdata;
      mx[0][wr_sel]    = core_wdata;
    end
    if (spr_en && spr_we && inw) begin
      mf[off / NR][off % NR] = spr_wdata;
      mx[off / NR][off % NR] = spr_wdata;
    end
    ovff = 1'b0;
    udff = 1'b0;
    if (exc_enter && !exc_return) begin
      if (ctxf == NB - 1) ovff = 1'b1;
      else                ctxf++;
    end else if (exc_return && !exc_enter) begin
      if (ctxf == 0) udff = 1'b1;
      else           ctxf--;
    end
  endtask

  // Called just after a falling edge with inputs already driven.
  task automatic cyc();
    #4;
    compare();
    @(posedge clk);
    update();
    @(negedge clk);
  endtask

  task automatic idle();
    core_we = 1'b0; spr_en = 1'b0; spr_we = 1'b0;
    exc_enter = 1'b0; exc_return = 1'b0;
  endtask

  task automatic spr_access(bit we, int addr, logic [31:0] data);
    spr_en = 1'b1; spr_we = we; spr_addr = 16'(addr); spr_wdata = data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < NR; r++) begin
        mf[b][r] = '0;
        mx[b][r] = '0;
      end
    ctxf = 0; ovff = 1'b0; udff = 1'b0;
    rst_n = 1'b0;
    rd_a_sel = '0; rd_b_sel = '0; wr_sel = '0;
    core_wdata = '0; spr_wdata = '0; spr_addr = '0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: idle cycles cover the synchronizer, then reads of assorted words
    phase = "R1 reset";
    cyc(); cyc(); cyc();
    for (int k = 0; k < 8; k++) begin
      spr_access(1'b0, BASE + k * 67, 32'h0);
      rd_a_sel = 5'(k); rd_b_sel = 5'(31 - k);
      cyc();
    end
    idle();

    // R2: core writes in context 0, then read back
    phase = "R2 core";
    for (int k = 0; k < 8; k++) begin
      core_we = 1'b1; wr_sel = 5'(k * 4 + 1); core_wdata = 32'hC0DE_0000 + k;
      cyc();
    end
    idle();
    for (int k = 0; k < 8; k++) begin
      rd_a_sel = 5'(k * 4 + 1); rd_b_sel = 5'(k * 4);
      cyc();
    end

    // R3 R4: window writes into every bank, then read back
    phase = "R3 R4 window";
    for (int b = 0; b < NB; b++) begin
      spr_access(1'b1, BASE + b * NR + (b + 3) % NR, 32'hBA00_0000 + b);
      cyc();
    end
    for (int b = 0; b < NB; b++) begin
      spr_access(1'b0, BASE + b * NR + (b + 3) % NR, 32'h0);
      cyc();
    end
    spr_access(1'b1, BASE + NW - 1, 32'h1A57_0001); cyc();
    spr_access(1'b1, BASE, 32'hF125_7000); cyc();
    spr_access(1'b0, BASE + NW - 1, 32'h0); cyc();
    idle();

    // R8: step into bank 3 and read what the window placed there
    phase = "R8 enter";
    for (int k = 0; k < 3; k++) begin exc_enter = 1'b1; cyc(); end
    idle();
    rd_a_sel = 5'd6; rd_b_sel = 5'd1;
    cyc();

    // R6: same-word collision, then different words in one cycle
    phase = "R6 collide";
    core_we = 1'b1; wr_sel = 5'd6; core_wdata = 32'hAAAA_0006;
    spr_access(1'b1, BASE + 3 * NR + 6, 32'h5555_0006);
    cyc();
    wr_sel = 5'd9; core_wdata = 32'hAAAA_0009;
    spr_access(1'b1, BASE + 3 * NR + 10, 32'h5555_000A);
    cyc();
    idle();
    rd_a_sel = 5'd9; rd_b_sel = 5'd10;
    spr_access(1'b0, BASE + 3 * NR + 6, 32'h0);
    cyc();
    idle();

    // R7: reads of words written in the same cycle show old data
    phase = "R7 same-cycle";
    core_we = 1'b1; wr_sel = 5'd9; core_wdata = 32'h7777_0009;
    rd_a_sel = 5'd9; rd_b_sel = 5'd9;
    spr_access(1'b1, BASE + 3 * NR + 10, 32'h7777_000A);
    cyc();
    core_we = 1'b0;
    spr_access(1'b1, BASE + 3 * NR + 10, 32'h8888_000A);
    cyc();
    idle();
    cyc();

    // R5: addresses outside the window
    phase = "R5 miss";
    spr_access(1'b1, BASE - 1, 32'hDEAD_0001); cyc();
    spr_access(1'b1, BASE + NW, 32'hDEAD_0002); cyc();
    spr_access(1'b1, 0, 32'hDEAD_0003); cyc();
    spr_access(1'b1, 16'hFFFF, 32'hDEAD_0004); cyc();
    spr_access(1'b0, BASE - 1, 32'h0); cyc();
    spr_access(1'b0, BASE + NW, 32'h0); cyc();
    spr_access(1'b0, BASE + NW - 1, 32'h0); cyc();
    spr_access(1'b0, BASE + 31, 32'h0); cyc();
    idle();
    spr_addr = 16'd5; cyc();

    // R9: saturate high, then low
    phase = "R9 saturate";
    for (int k = 0; k < 16; k++) begin exc_enter = 1'b1; cyc(); end
    idle(); cyc();
    for (int k = 0; k < 19; k++) begin exc_return = 1'b1; cyc(); end
    idle(); cyc();

    // R8: both strobes together at context 0 and mid-range
    phase = "R8 both";
    exc_enter = 1'b1; exc_return = 1'b1; cyc();
    idle();
    for (int k = 0; k < 5; k++) begin exc_enter = 1'b1; cyc(); end
    exc_return = 1'b1; cyc();
    idle(); cyc();
    exc_return = 1'b1; cyc();
    idle(); cyc();

    // Random traffic through every port
    phase = "R2 R3 R4 R6 R8 random";
    for (int n = 0; n < 3000; n++) begin
      int sel;
      rd_a_sel   = 5'($urandom);
      rd_b_sel   = 5'($urandom);
      core_we    = ($urandom % 2) == 0;
      wr_sel     = 5'($urandom);
      core_wdata = $urandom;
      spr_en     = ($urandom % 4) != 0;
      spr_we     = ($urandom % 2) == 0;
      sel        = $urandom % 8;
      if (sel < 6)       spr_addr = 16'(BASE + ($urandom % NW));
      else if (sel == 6) spr_addr = 16'(BASE + NW + ($urandom % 64));
      else               spr_addr = 16'($urandom % BASE);
      if (($urandom % 5) == 0 && core_we && spr_en && spr_we)
        spr_addr = 16'(BASE + ctxf * NR + int'(wr_sel));
      spr_wdata  = $urandom;
      exc_enter  = ($urandom % 6) == 0;
      exc_return = ($urandom % 6) == 0;
      cyc();
    end
    idle();
    cyc();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule